// File: doc/BRIEF.md
# Flash write unlock controller

This block sits between a processor's register bus and a nonvolatile program memory array. It holds the address pointer, the data byte and the control bits that the processor sets up before an array cycle. A program or erase cycle can begin only after software has written a two-value key, 55h then AAh, to a key register that has no storage behind it, and then sets the start bit as its very next bus access. While the cycle runs, the block raises a stall output toward the processor and holds a request toward the array until the array reports done.

A one-cycle read path copies the addressed array byte into the data latch. If a warm reset (external pin or watchdog) cuts a running cycle short, a sticky error bit is left set so software can detect the failure and rewrite the location. Only a power-on reset clears that bit.

Register offsets on the 3-bit bus address: 0 control, 1 key, 2 pointer bits 7:0, 3 pointer bits 15:8, 4 pointer bits 20:16, 5 data latch. Control bits: bit0 write-enable, bit1 start (reads 1 while a cycle runs), bit2 read, bit3 erase select, bit4 write error, bit5 configuration-space select, bit6 program-flash select (0 selects data EEPROM), bit7 reads 0.

Top module: `flash_unlock_ctrl`

## Requirements
- R1: A start request (control write with bit1 = 1) begins a cycle only when the previous two bus accesses were a key write (offset 1) of 55h and then a key write of AAh.
- R2: Any bus access other than the expected next step (wrong key value, a write or read to another offset) returns the unlock sequence to idle, and a later start request is ignored.
- R3: A start request is ignored unless the write-enable bit (control bit0) was already 1 before that write.
- R4: A read of the key register (offset 1) returns 00h.
- R5: cpu_stall and fl_req are 1 from the cycle after an accepted start until the clock edge at which fl_done is sampled 1.
- R6: When the cycle completes, control bit1 reads 0 and done_flag becomes 1; done_flag clears when the next start is accepted.
- R7: The 21-bit pointer is written and read as offset 2 (bits 7:0), offset 3 (bits 15:8) and offset 4 (bits 20:16, read bits 7:5 are 0), and drives fl_addr; the data latch (offset 5) drives fl_wdata.
- R8: Control bit3 drives fl_erase, bit5 drives fl_cfg_sel and bit6 drives fl_flash_sel, and all three read back in place.
- R9: Writing control bit2 = 1 raises fl_rd for exactly one cycle, the data latch captures fl_rdata at the end of that cycle, and bit2 then reads 0.
- R10: A warm_rst during a running cycle aborts it, sets the error bit (control bit4) and clears all other registers; a warm_rst while idle leaves the error bit as it was.
- R11: The error bit survives warm_rst and is cleared only by the power-on reset rst_n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, asynchronous, active low |
| warm_rst | input | 1 | External or watchdog reset, synchronous, active high |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected offset |
| fl_req | output | 1 | Program/erase request to the array |
| fl_erase | output | 1 | Erase instead of program |
| fl_flash_sel | output | 1 | 1 = program flash, 0 = data EEPROM |
| fl_cfg_sel | output | 1 | 1 = configuration space |
| fl_addr | output | 21 | Array address from the pointer |
| fl_wdata | output | 8 | Array write data from the latch |
| fl_rd | output | 1 | One-cycle array read strobe |
| fl_rdata | input | 8 | Array read data |
| fl_done | input | 1 | Array cycle finished |
| cpu_stall | output | 1 | Processor stall while a cycle runs |
| done_flag | output | 1 | Completion flag |

## Verification
A wrong unlock state shows at the ports one cycle after the start write: cpu_stall and fl_req either rise when the key sequence was broken or stay low after a clean sequence. A busy state that fails to track the array shows as cpu_stall held past the fl_done edge or dropped before it, and a lost or stray error bit shows on the next control read after a warm reset. Read strobe and latch errors appear on the data latch read that follows the read request.

// File: rtl/flash_unlock_ctrl.sv
module flash_unlock_ctrl #(
  parameter int ADDR_W = 21,
  parameter logic [7:0] KEY_A = 8'h55,
  parameter logic [7:0] KEY_B = 8'hAA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              warm_rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [2:0]        bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              fl_req,
  output logic              fl_erase,
  output logic              fl_flash_sel,
  output logic              fl_cfg_sel,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [7:0]        fl_wdata,
  output logic              fl_rd,
  input  logic [7:0]        fl_rdata,
  input  logic              fl_done,
  output logic              cpu_stall,
  output logic              done_flag
);
  localparam int UP_W = ADDR_W - 16;
  localparam int PAD  = 8 - UP_W;
  localparam logic [2:0] A_CTRL = 3'd0, A_KEY = 3'd1, A_PLO = 3'd2,
                         A_PHI = 3'd3, A_PUP = 3'd4, A_LAT = 3'd5;

  typedef enum logic [1:0] {U_IDLE, U_GOT_A, U_ARMED} ustate_t;

  ustate_t            ust;
  logic               wren, busy, rd_q, erase, cfg, fsel, err, done_q;
  logic [ADDR_W-1:0]  ptr;
  logic [7:0]         latch;

  wire wr      = bus_sel & bus_we;
  wire ctrl_wr = wr && bus_addr == A_CTRL;
  wire key_a   = wr && bus_addr == A_KEY && bus_wdata == KEY_A;
  wire key_b   = wr && bus_addr == A_KEY && bus_wdata == KEY_B;
  wire go      = ctrl_wr && bus_wdata[1] && ust == U_ARMED && wren && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ust <= U_IDLE;
    else if (warm_rst) ust <= U_IDLE;
    else if (bus_sel) begin
      if (key_a) ust <= U_GOT_A;
      else if (key_b && ust == U_GOT_A) ust <= U_ARMED;
      else ust <= U_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {wren, busy, rd_q, erase, cfg, fsel, err, done_q} <= '0;
      ptr   <= '0;
      latch <= '0;
    end else if (warm_rst) begin
      err <= err | busy;
      {wren, busy, rd_q, erase, cfg, fsel, done_q} <= '0;
      ptr   <= '0;
      latch <= '0;
    end else begin
      if (ctrl_wr) begin
        wren  <= bus_wdata[0];
        erase <= bus_wdata[3];
        cfg   <= bus_wdata[5];
        fsel  <= bus_wdata[6];
      end
      if (rd_q) begin
        rd_q  <= 1'b0;
        latch <= fl_rdata;
      end else begin
        if (ctrl_wr && bus_wdata[2] && !busy) rd_q <= 1'b1;
        if (wr && bus_addr == A_LAT) latch <= bus_wdata;
      end
      if (wr && bus_addr == A_PLO) ptr[7:0] <= bus_wdata;
      if (wr && bus_addr == A_PHI) ptr[15:8] <= bus_wdata;
      if (wr && bus_addr == A_PUP) ptr[ADDR_W-1:16] <= bus_wdata[UP_W-1:0];
      if (go) begin
        busy   <= 1'b1;
        done_q <= 1'b0;
      end else if (busy && fl_done) begin
        busy   <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = {1'b0, fsel, cfg, err, erase, rd_q, busy, wren};
      A_PLO:   bus_rdata = ptr[7:0];
      A_PHI:   bus_rdata = ptr[15:8];
      A_PUP:   bus_rdata = {{PAD{1'b0}}, ptr[ADDR_W-1:16]};
      A_LAT:   bus_rdata = latch;
      default: bus_rdata = 8'h00;
    endcase
  end

  assign fl_req       = busy;
  assign cpu_stall    = busy;
  assign done_flag    = done_q;
  assign fl_erase     = erase;
  assign fl_flash_sel = fsel;
  assign fl_cfg_sel   = cfg;
  assign fl_addr      = ptr;
  assign fl_wdata     = latch;
  assign fl_rd        = rd_q;

  AST_START_AFTER_KEYS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(ust == U_ARMED)); // R1
  AST_START_NEEDS_WREN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wren)); // R3
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !fl_done && !warm_rst |=> busy); // R5
  AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    busy && fl_done && !warm_rst |=> !busy && done_q); // R6
  AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_q |=> !rd_q); // R9
  AST_ABORT_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    warm_rst && busy |=> err && !busy); // R10
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err); // R11
endmodule

// File: tb/flash_unlock_ctrl_bench.sv
module flash_unlock_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        warm_rst = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        fl_req, fl_erase, fl_flash_sel, fl_cfg_sel, fl_rd, cpu_stall, done_flag;
  logic [20:0] fl_addr;
  logic [7:0]  fl_wdata;
  logic [7:0]  fl_rdata = 8'hA5;
  logic        fl_done = 1'b0;

  int total = 0, bad = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  flash_unlock_ctrl u_flash_unlock_ctrl (
    .clk(clk), .rst_n(rst_n), .warm_rst(warm_rst),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .fl_req(fl_req), .fl_erase(fl_erase), .fl_flash_sel(fl_flash_sel),
    .fl_cfg_sel(fl_cfg_sel), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
    .fl_rd(fl_rd), .fl_rdata(fl_rdata), .fl_done(fl_done),
    .cpu_stall(cpu_stall), .done_flag(done_flag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (bus_sel && !bus_we && exp_q.size() > 0) begin
      automatic logic [7:0] e = exp_q.pop_front();
      automatic string t = tag_q.pop_front();
      chk(t, bus_rdata, e);
    end
  end

  task automatic bw(logic [2:0] a, logic [7:0] d);
    @(posedge clk); #1;
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic br(logic [2:0] a, logic [7:0] e, string t);
    @(posedge clk); #1;
    bus_sel = 1; bus_we = 0; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(posedge clk); #1;
    bus_sel = 0;
  endtask

  task automatic pulse_done();
    @(posedge clk); #1; fl_done = 1;
    @(posedge clk); #1; fl_done = 0;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("reset stall R5", cpu_stall, 0);
    chk("reset done R6", done_flag, 0);
    br(3'd0, 8'h00, "reset ctrl R11");

    // pointer and latch
    bw(3'd2, 8'h34); bw(3'd3, 8'h12); bw(3'd4, 8'hFF); bw(3'd5, 8'h5A);
    br(3'd4, 8'h1F, "ptr upper R7");
    br(3'd3, 8'h12, "ptr high R7");
    @(negedge clk);
    chk("fl_addr R7", fl_addr, 21'h1F1234);
    chk("fl_wdata R7", fl_wdata, 8'h5A);
    br(3'd1, 8'h00, "key reads zero R4");

    // clean unlock
    bw(3'd0, 8'h01); bw(3'd1, 8'h55); bw(3'd1, 8'hAA); bw(3'd0, 8'h03);
    @(negedge clk);
    chk("start stall R1", cpu_stall, 1);
    chk("start req R5", fl_req, 1);
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("stall held R5", cpu_stall, 1);
    br(3'd0, 8'h03, "busy readback R6");
    pulse_done();
    @(negedge clk);
    chk("stall released R5", cpu_stall, 0);
    chk("done set R6", done_flag, 1);
    br(3'd0, 8'h01, "start cleared R6");

    // wrong order
    bw(3'd1, 8'hAA); bw(3'd1, 8'h55); bw(3'd0, 8'h03);
    @(negedge clk);
    chk("wrong order R2", cpu_stall, 0);
    // interrupted by other write
    bw(3'd1, 8'h55); bw(3'd1, 8'hAA); bw(3'd2, 8'h00); bw(3'd0, 8'h03);
    @(negedge clk);
    chk("intervening write R2", cpu_stall, 0);
    // interrupted by a read
    bw(3'd1, 8'h55); br(3'd5, 8'h5A, "latch read R7"); bw(3'd1, 8'hAA); bw(3'd0, 8'h03);
    @(negedge clk);
    chk("intervening read R2", cpu_stall, 0);
    // wren clear
    bw(3'd0, 8'h00); bw(3'd1, 8'h55); bw(3'd1, 8'hAA); bw(3'd0, 8'h03);
    @(negedge clk);
    chk("no wren R3", cpu_stall, 0);
    chk("done kept R6", done_flag, 1);

    // select bits
    bw(3'd0, 8'h68);
    @(negedge clk);
    chk("erase R8", fl_erase, 1);
    chk("cfg R8", fl_cfg_sel, 1);
    chk("flash sel R8", fl_flash_sel, 1);
    br(3'd0, 8'h68, "select readback R8");

    // read path
    bw(3'd0, 8'h04);
    @(negedge clk);
    chk("rd strobe R9", fl_rd, 1);
    @(negedge clk);
    chk("rd one cycle R9", fl_rd, 0);
    br(3'd5, 8'hA5, "latch captured R9");
    br(3'd0, 8'h00, "rd bit cleared R9");

    // done flag clears on next start, then warm reset aborts
    bw(3'd0, 8'h01); bw(3'd1, 8'h55); bw(3'd1, 8'hAA); bw(3'd0, 8'h03);
    @(negedge clk);
    chk("second start R1", cpu_stall, 1);
    chk("done cleared R6", done_flag, 0);
    @(posedge clk); #1 warm_rst = 1;
    @(posedge clk); #1 warm_rst = 0;
    @(negedge clk);
    chk("abort stall R10", cpu_stall, 0);
    br(3'd0, 8'h10, "error set R10");
    br(3'd2, 8'h00, "ptr cleared R10");
    @(posedge clk); #1 warm_rst = 1;
    @(posedge clk); #1 warm_rst = 0;
    br(3'd0, 8'h10, "error survives warm R11");

    // warm reset while idle leaves error clear
    @(posedge clk); #1 rst_n = 0;
    @(posedge clk); #1 rst_n = 1;
    br(3'd0, 8'h00, "por clears error R11");
    @(posedge clk); #1 warm_rst = 1;
    @(posedge clk); #1 warm_rst = 0;
    br(3'd0, 8'h00, "idle warm no error R10");

    repeat (2) @(posedge clk);
    chk("queue drained", exp_q.size(), 0);
    finish_run();
  end
endmodule